// File: doc/BRIEF.md
# Threshold Trigger Detector

This block watches a stream of ADC sample codes and raises a capture trigger when the signal meets a software-chosen condition against an 8-bit threshold. Software computes the threshold as the trigger voltage's fraction of full scale times 256, rounded. Only the most significant byte of each sample code is compared with it. In bipolar mode that byte is treated as two's complement. In unipolar mode it is treated as unsigned.

Two select bits pick one of four conditions: a rising crossing, a falling crossing, "above" or "below". Triggering is gated by an active-low arm input and by a burst-acquisition enable. Software may keep sampling with the trigger disarmed and arm it at any point. Each arming period yields at most one trigger pulse. A sticky flag records that the trigger fired, and it stays set until the block is disarmed.

Top module: `thr_trig`

## Requirements
- R1: After reset, `trig_pulse` and `trig_seen` are 0.
- R2: The compared value is `smp_code[11:4]`. The sample counts as "above" when that byte is strictly greater than `thr` and as "below" when it is strictly less. The comparison is unsigned when `bipolar`=0 and two's-complement signed when `bipolar`=1.
- R3: With `level_mode`=0 and `pol_sel`=1 (rising), a valid sample triggers when the previous valid sample of the same arming period was not above and this one is above.
- R4: With `level_mode`=0 and `pol_sel`=0 (falling), a valid sample triggers when the previous valid sample of the same arming period was above and this one is not above.
- R5: With `level_mode`=1 and `pol_sel`=1, any valid sample that is above triggers.
- R6: With `level_mode`=1 and `pol_sel`=0, any valid sample that is below triggers.
- R7: The block is armed only while `arm_n`=0 and `burst_en`=1. No trigger occurs while it is disarmed, and a cycle with `smp_vld`=0 never triggers.
- R8: The crossing history is cleared while the block is disarmed. The first valid sample after arming can never produce an edge trigger.
- R9: Once the trigger has fired, no further pulse occurs until the block is disarmed and armed again. `trig_seen` stays 1 while the block remains armed and returns to 0 in the cycle after it is disarmed.
- R10: `trig_pulse` goes high for exactly one cycle, in the cycle after the clock edge at which the triggering sample is taken. `trig_seen` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | A new sample is present this cycle |
| smp_code | input | 12 | Sample code, two's complement in bipolar mode |
| thr | input | 8 | Threshold, compared with the top byte of the sample |
| level_mode | input | 1 | 1 = level condition, 0 = edge condition |
| pol_sel | input | 1 | 1 = rising/above, 0 = falling/below |
| arm_n | input | 1 | Active-low arm |
| burst_en | input | 1 | Burst acquisition active; arming has effect only when 1 |
| bipolar | input | 1 | 1 = signed comparison, 0 = unsigned |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_seen | output | 1 | Sticky flag: the trigger fired during this arming period |

## Verification
The hardest case to reach is an arming edge that meets a stale comparison state. The last sample before disarming sat on one side of the threshold, and the first sample after arming sits on the other side. A design that kept its history would then raise a false edge. The stimulus builds this case on purpose: it holds the block disarmed on a sample below the threshold, then arms it with a sample above. Random stimulus adds more such cases by drawing codes within a few steps of the threshold and toggling the arm bit while samples keep arriving. Signed-versus-unsigned ordering is forced with a threshold and a code whose top bits differ.

// File: rtl/thr_trig_pkg.sv
package thr_trig_pkg;

    typedef enum logic [1:0] {
        COND_RISE  = 2'b00,
        COND_FALL  = 2'b01,
        COND_ABOVE = 2'b10,
        COND_BELOW = 2'b11
    } trig_cond_e;

    typedef struct packed {
        logic prev_above;
        logic hist_vld;
        logic fired;
        logic pulse;
    } trig_state_t;

    function automatic trig_cond_e cond_from_bits(input logic level_sel, input logic pol);
        return trig_cond_e'({level_sel, ~pol});
    endfunction

endpackage

// File: rtl/thr_trig_cmp.sv
module thr_trig_cmp #(
    parameter int THR_W = 8
) (
    input  logic [THR_W-1:0] top_byte,
    input  logic [THR_W-1:0] thr,
    input  logic             bipolar,
    output logic             is_above,
    output logic             is_below
);
    localparam logic [THR_W-1:0] SIGN_BIAS = {1'b1, {(THR_W-1){1'b0}}};

    logic [THR_W-1:0] bias;
    logic [THR_W-1:0] a_biased;
    logic [THR_W-1:0] b_biased;

    // Flipping the sign bit maps two's-complement order onto unsigned order.
    always_comb begin
        bias     = bipolar ? SIGN_BIAS : '0;
        a_biased = top_byte ^ bias;
        b_biased = thr ^ bias;
        is_above = a_biased > b_biased;
        is_below = a_biased < b_biased;
    end
endmodule

// File: rtl/thr_trig_ctl.sv
module thr_trig_ctl
    import thr_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       smp_vld,
    input  trig_cond_e cond,
    input  logic       is_above,
    input  logic       is_below,
    output logic       trig_pulse,
    output logic       trig_seen
);
    trig_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!armed) begin
            st_d = '0;
        end else begin
            st_d.pulse = 1'b0;
            if (smp_vld) begin
                unique case (cond)
                    COND_RISE:  hit = st_q.hist_vld && !st_q.prev_above && is_above;
                    COND_FALL:  hit = st_q.hist_vld && st_q.prev_above && !is_above;
                    COND_ABOVE: hit = is_above;
                    default:    hit = is_below;
                endcase
                if (hit && !st_q.fired) begin
                    st_d.pulse = 1'b1;
                    st_d.fired = 1'b1;
                end
                st_d.prev_above = is_above;
                st_d.hist_vld   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_pulse = st_q.pulse;
    assign trig_seen  = st_q.fired;

    assert_disarm_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (!trig_pulse && !trig_seen));
    assert_no_sample_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !trig_pulse);
    assert_first_sample_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !st_q.hist_vld && !cond[1]) |=> !trig_pulse);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    assert_pulse_sets_seen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> trig_seen);
    assert_seen_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_seen && armed) |=> (trig_seen && !trig_pulse));
endmodule

// File: rtl/thr_trig.sv
module thr_trig
    import thr_trig_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THR_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_code,
    input  logic [THR_W-1:0]    thr,
    input  logic                level_mode,
    input  logic                pol_sel,
    input  logic                arm_n,
    input  logic                burst_en,
    input  logic                bipolar,
    output logic                trig_pulse,
    output logic                trig_seen
);
    localparam int LOW_W = SAMPLE_W - THR_W;

    logic [THR_W-1:0] top_byte;
    logic             unused_low_bits;
    logic             armed;
    logic             is_above;
    logic             is_below;
    trig_cond_e       cond;

    assign top_byte        = smp_code[SAMPLE_W-1 -: THR_W];
    assign unused_low_bits = ^smp_code[LOW_W-1:0];
    assign armed           = !arm_n && burst_en;
    assign cond            = cond_from_bits(level_mode, pol_sel);

    thr_trig_cmp #(.THR_W(THR_W)) u_cmp (
        .top_byte (top_byte),
        .thr      (thr),
        .bipolar  (bipolar),
        .is_above (is_above),
        .is_below (is_below)
    );

    thr_trig_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .smp_vld    (smp_vld),
        .cond       (cond),
        .is_above   (is_above),
        .is_below   (is_below),
        .trig_pulse (trig_pulse),
        .trig_seen  (trig_seen)
    );

    // The most negative signed threshold can never be undercut.
    assert_signed_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bipolar && thr == {1'b1, {(THR_W-1){1'b0}}}) |-> !is_below);
    // Above and below are mutually exclusive.
    assert_cmp_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_above && is_below));
endmodule

// File: tb/thr_trig_bench.sv
`timescale 1ns/1ps
module thr_trig_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_code = '0;
    logic [7:0]  thr = '0;
    logic        level_mode = 1'b0;
    logic        pol_sel = 1'b1;
    logic        arm_n = 1'b1;
    logic        burst_en = 1'b0;
    logic        bipolar = 1'b0;
    logic        trig_pulse;
    logic        trig_seen;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    bit    m_prev = 0, m_hist = 0, m_fired = 0;
    bit    exp_pulse = 0, exp_seen = 0;
    string exp_tag = "R1";

    always #2.5 clk = ~clk;

    thr_trig u_thr_trig (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code), .thr(thr),
        .level_mode(level_mode), .pol_sel(pol_sel), .arm_n(arm_n), .burst_en(burst_en),
        .bipolar(bipolar), .trig_pulse(trig_pulse), .trig_seen(trig_seen)
    );

    task automatic check(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic bit ref_above(input logic [11:0] c, input logic [7:0] t, input logic b);
        if (b) return $signed(c[11:4]) > $signed(t);
        return c[11:4] > t;
    endfunction

    function automatic bit ref_below(input logic [11:0] c, input logic [7:0] t, input logic b);
        if (b) return $signed(c[11:4]) < $signed(t);
        return c[11:4] < t;
    endfunction

    // Check the outputs caused by the previous step, then apply new inputs and predict.
    task automatic step(input logic v, input logic [11:0] c, input logic [7:0] t,
                        input logic lv, input logic p, input logic an, input logic be,
                        input logic b, input string tag);
        bit ab, be_l, hit, arm;
        @(negedge clk);
        check(exp_tag, trig_pulse, exp_pulse);
        check("R9", trig_seen, exp_seen);
        smp_vld = v; smp_code = c; thr = t; level_mode = lv; pol_sel = p;
        arm_n = an; burst_en = be; bipolar = b;
        arm  = !an && be;
        ab   = ref_above(c, t, b);
        be_l = ref_below(c, t, b);
        hit  = 0;
        exp_pulse = 0;
        if (!arm) begin
            m_prev = 0; m_hist = 0; m_fired = 0;
        end else if (v) begin
            if (!lv && p)      hit = m_hist && !m_prev && ab;
            else if (!lv)      hit = m_hist && m_prev && !ab;
            else if (p)        hit = ab;
            else               hit = be_l;
            if (hit && !m_fired) begin
                exp_pulse = 1; m_fired = 1;
            end
            m_prev = ab; m_hist = 1;
        end
        exp_seen = m_fired;
        if (tag != "") exp_tag = tag;
        else if (!arm || !v) exp_tag = "R7";
        else if (!lv) exp_tag = p ? "R3" : "R4";
        else exp_tag = p ? "R5" : "R6";
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        logic [7:0] t;
        logic lv, p, an, be, b;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", trig_pulse, 1'b0);
        check("R1", trig_seen, 1'b0);
        rst_n = 1'b1;

        // R8: disarmed on a low sample, then armed on a high one: no rising edge
        step(1, 12'h100, 8'h40, 0, 1, 1, 1, 0, "R8");
        step(1, 12'h500, 8'h40, 0, 1, 0, 1, 0, "R8");
        step(1, 12'h100, 8'h40, 0, 1, 0, 1, 0, "R3");
        step(1, 12'h500, 8'h40, 0, 1, 0, 1, 0, "R3");   // rising edge fires
        step(1, 12'h100, 8'h40, 0, 1, 0, 1, 0, "R10");  // pulse seen here, one cycle
        step(1, 12'h500, 8'h40, 0, 1, 0, 1, 0, "R10");
        step(1, 12'h500, 8'h40, 0, 1, 0, 1, 0, "R9");   // second edge was ignored
        step(0, 12'h000, 8'h40, 0, 1, 1, 1, 0, "R9");   // disarm
        step(0, 12'h000, 8'h40, 0, 1, 1, 1, 0, "R9");
        // R2: signed vs unsigned: top 0x10 vs thr 0xF0
        step(1, 12'h100, 8'hF0, 1, 1, 0, 1, 0, "R2");   // unsigned: not above
        step(1, 12'h100, 8'hF0, 1, 1, 0, 1, 0, "R2");
        step(1, 12'h100, 8'hF0, 1, 1, 1, 1, 1, "R2");
        step(1, 12'h100, 8'hF0, 1, 1, 0, 1, 1, "R2");   // signed: above, fires
        step(1, 12'h100, 8'hF0, 1, 0, 1, 1, 1, "R2");
        // R6: equal is neither above nor below
        step(1, 12'h40F, 8'h40, 1, 0, 0, 1, 0, "R6");
        step(1, 12'h3FF, 8'h40, 1, 0, 0, 1, 0, "R6");
        // R7: armed bit low but burst off
        step(1, 12'hFFF, 8'h00, 1, 1, 0, 0, 0, "R7");
        step(1, 12'hFFF, 8'h00, 1, 1, 0, 0, 0, "R7");
        // R4: falling edge
        step(1, 12'h800, 8'h40, 0, 0, 0, 1, 0, "R4");
        step(1, 12'h100, 8'h40, 0, 0, 0, 1, 0, "R4");
        step(0, 12'h100, 8'h40, 0, 0, 0, 1, 0, "R4");
        step(0, 12'h100, 8'h40, 0, 0, 1, 1, 0, "R7");

        lv = 0; p = 1; an = 1; be = 1; b = 0; t = 8'h80;
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] top;
            logic [11:0] c;
            if ($urandom_range(0, 29) == 0) an = ~an;
            if ($urandom_range(0, 199) == 0) be = ~be;
            if ($urandom_range(0, 99) == 0) begin
                lv = 1'($urandom); p = 1'($urandom); b = 1'($urandom);
                t = 8'($urandom);
            end
            top = t + 8'($urandom_range(0, 6)) - 8'd3;
            c = {top, 4'($urandom)};
            step(($urandom_range(0, 9) < 7), c, t, lv, p, an, be, b, "");
        end
        step(0, 12'h000, 8'h00, 0, 1, 1, 1, 0, "");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule